// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block is the control logic for a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). Each cycle it takes the source register IDs of the instruction in decode and compares them with the destination IDs of the instructions further down the pipe. It chooses, for each of the two operands, where the value should come from: the register file or one of five bypass points. It also drives the stall and bubble controls of every pipeline register. The datapath, the ALU and the memories sit outside the block. The block only sees register IDs, a few instruction-kind flags and the status code carried with each instruction.

Three conditions stop or cancel instructions. A load in execute whose destination is needed by decode holds decode and fetch for one cycle and puts a bubble into execute. A return instruction anywhere from decode to memory holds fetch until it leaves the memory stage. A mispredicted branch found in execute puts bubbles into decode and execute, which cancels the two younger instructions. Status codes move with instructions. Once a faulting instruction reaches memory or write-back, the block stops younger instructions from writing the condition codes or data memory. When the fault reaches write-back, the block raises a sticky halt.

Top module: `hzd_ctrl`

## Requirements
- R1: After a synchronous reset, `halted` is 0.
- R2: Each operand select takes its code from the first match, checked in this order: execute ALU destination (code 1), memory-stage load destination (2), memory-stage ALU destination (3), write-back load destination (4), write-back ALU destination (5). If nothing matches, the code is register file (0). An ID of 0xF in a destination field means that field is unused.
- R3: A source ID of 0xF never matches anything. Its select is 0, and it never causes a load/use stall.
- R4: A load/use hazard exists when `ex_dst_load` is not 0xF, it equals a decode source that is not 0xF, and `ex_mispredict` is 0. During a load/use hazard, `f_stall`, `d_stall` and `e_bubble` are 1. An execute-stage load destination is never given as a forward code.
- R5: A return is pending when `ex_is_ret` or `mem_is_ret` is 1, or when `dec_is_ret` is 1 and `ex_mispredict` is 0. While a return is pending, `f_stall` is 1. `d_bubble` is also 1 unless a load/use hazard is holding decode.
- R6: When `ex_mispredict` is 1, `d_bubble` and `e_bubble` are 1 and `d_stall` is 0. A load/use match in the same cycle is ignored.
- R7: A status code of 0 means OK. Any other code is an exception (1 halt, 2 bad address, 3 bad instruction). `cc_we` equals `ex_sets_cc` and is forced to 0 when `ex_stat`, `mem_stat` or `wb_stat` is non-zero, or when `halted` is 1. `dmem_we` equals `mem_wr_req` and is forced to 0 when `mem_stat` or `wb_stat` is non-zero, or when `halted` is 1.
- R8: `m_bubble` is 1 when `mem_stat` is non-zero, when `wb_stat` is non-zero, or when `halted` is 1. `w_stall` is 1 when `wb_stat` is non-zero or when `halted` is 1.
- R9: `halted` becomes 1 on the clock edge after a non-zero `wb_stat` is seen. It then stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_src_a | input | 4 | First source register ID in decode (0xF = none) |
| dec_src_b | input | 4 | Second source register ID in decode (0xF = none) |
| dec_is_ret | input | 1 | Decode holds a return |
| ex_dst_alu | input | 4 | ALU-result destination of the execute instruction |
| ex_dst_load | input | 4 | Load destination of the execute instruction (0xF = not a load) |
| ex_is_ret | input | 1 | Execute holds a return |
| ex_mispredict | input | 1 | Branch in execute was mispredicted |
| ex_sets_cc | input | 1 | Execute instruction wants to write condition codes |
| ex_stat | input | 2 | Status of the execute instruction |
| mem_dst_alu | input | 4 | ALU-result destination in memory stage |
| mem_dst_load | input | 4 | Load destination in memory stage |
| mem_is_ret | input | 1 | Memory stage holds a return |
| mem_wr_req | input | 1 | Memory-stage instruction wants to write data memory |
| mem_stat | input | 2 | Status of the memory-stage instruction |
| wb_dst_alu | input | 4 | ALU-result destination in write-back |
| wb_dst_load | input | 4 | Load destination in write-back |
| wb_stat | input | 2 | Status of the write-back instruction |
| fwd_a_sel | output | 3 | Operand A source code |
| fwd_b_sel | output | 3 | Operand B source code |
| f_stall | output | 1 | Hold the fetch register |
| d_stall | output | 1 | Hold the decode register |
| d_bubble | output | 1 | Load a bubble into the decode register |
| e_bubble | output | 1 | Load a bubble into the execute register |
| m_bubble | output | 1 | Load a bubble into the memory register |
| w_stall | output | 1 | Hold the write-back register |
| cc_we | output | 1 | Condition-code write enable |
| dmem_we | output | 1 | Data-memory write enable |
| halted | output | 1 | Sticky halt flag |

## Verification
Two functions can meet in the same cycle: a load/use match and a branch mispredict. Both are decided by the instruction in execute, and they give opposite orders for decode (hold it or cancel it). The bench provokes the collision in a directed step, where the load destination equals a decode source while `ex_mispredict` is 1. It also provokes it many times in the biased random phase. In that cycle the stall must give way: `d_stall` must be 0 while both bubbles are 1, and `f_stall` is raised only by a pending return. A second overlap is tested the same way: a return in decode together with a load/use hold, where `d_bubble` must stay 0.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
    localparam int REG_W  = 4;
    localparam int STAT_W = 2;

    typedef enum logic [2:0] {
        SRC_RF       = 3'd0,
        SRC_EX_ALU   = 3'd1,
        SRC_MEM_LOAD = 3'd2,
        SRC_MEM_ALU  = 3'd3,
        SRC_WB_LOAD  = 3'd4,
        SRC_WB_ALU   = 3'd5
    } fwd_src_e;

    typedef enum logic [STAT_W-1:0] {
        ST_OK   = 2'd0,
        ST_HALT = 2'd1,
        ST_ADDR = 2'd2,
        ST_INSN = 2'd3
    } stat_e;

    typedef struct packed {
        logic f_stall;
        logic d_stall;
        logic d_bubble;
        logic e_bubble;
    } front_ctl_t;

    function automatic logic is_exc(input logic [STAT_W-1:0] s);
        return s != ST_OK;
    endfunction
endpackage

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel
    import hzd_pkg::*;
#(
    parameter int RW = REG_W
) (
    input  logic [RW-1:0] src,
    input  logic [RW-1:0] ex_alu,
    input  logic [RW-1:0] mem_load,
    input  logic [RW-1:0] mem_alu,
    input  logic [RW-1:0] wb_load,
    input  logic [RW-1:0] wb_alu,
    output fwd_src_e      sel
);
    localparam int          NCAND   = 5;
    localparam logic [RW-1:0] NO_REG = {RW{1'b1}};

    logic [RW-1:0] cand [NCAND];

    assign cand[0] = ex_alu;
    assign cand[1] = mem_load;
    assign cand[2] = mem_alu;
    assign cand[3] = wb_load;
    assign cand[4] = wb_alu;

    // Scan from oldest to youngest so the nearest stage overwrites last.
    always_comb begin
        sel = SRC_RF;
        if (src != NO_REG) begin
            for (int i = NCAND - 1; i >= 0; i--) begin
                if (cand[i] == src)
                    sel = fwd_src_e'(3'(i + 1));
            end
        end
    end
endmodule

// File: rtl/hzd_interlock.sv
module hzd_interlock
    import hzd_pkg::*;
#(
    parameter int RW = REG_W
) (
    input  logic [RW-1:0] src_a,
    input  logic [RW-1:0] src_b,
    input  logic          dec_is_ret,
    input  logic [RW-1:0] ex_dst_load,
    input  logic          ex_is_ret,
    input  logic          ex_mispredict,
    input  logic          mem_is_ret,
    output front_ctl_t    ctl
);
    localparam logic [RW-1:0] NO_REG = {RW{1'b1}};

    logic hit_a, hit_b, load_use, ret_wait;

    assign hit_a    = (src_a != NO_REG) && (src_a == ex_dst_load);
    assign hit_b    = (src_b != NO_REG) && (src_b == ex_dst_load);
    assign load_use = (hit_a || hit_b) && !ex_mispredict;
    assign ret_wait = (dec_is_ret && !ex_mispredict) || ex_is_ret || mem_is_ret;

    always_comb begin
        ctl.f_stall  = load_use || ret_wait;
        ctl.d_stall  = load_use;
        ctl.d_bubble = ex_mispredict || (ret_wait && !load_use);
        ctl.e_bubble = ex_mispredict || load_use;
    end
endmodule

// File: rtl/hzd_commit_guard.sv
module hzd_commit_guard
    import hzd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ex_sets_cc,
    input  logic [STAT_W-1:0] ex_stat,
    input  logic              mem_wr_req,
    input  logic [STAT_W-1:0] mem_stat,
    input  logic [STAT_W-1:0] wb_stat,
    output logic              cc_we,
    output logic              dmem_we,
    output logic              m_bubble,
    output logic              w_stall,
    output logic              halted
);
    logic exc_m, exc_w, stop_q;

    assign exc_m = is_exc(mem_stat);
    assign exc_w = is_exc(wb_stat);

    always_ff @(posedge clk) begin
        if (rst)
            stop_q <= 1'b0;
        else if (exc_w)
            stop_q <= 1'b1;
    end

    assign halted   = stop_q;
    assign w_stall  = exc_w || stop_q;
    assign m_bubble = exc_m || w_stall;
    assign dmem_we  = mem_wr_req && !m_bubble;
    assign cc_we    = ex_sets_cc && !is_exc(ex_stat) && !m_bubble;
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
    import hzd_pkg::*;
#(
    parameter int RW = REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RW-1:0]     dec_src_a,
    input  logic [RW-1:0]     dec_src_b,
    input  logic              dec_is_ret,
    input  logic [RW-1:0]     ex_dst_alu,
    input  logic [RW-1:0]     ex_dst_load,
    input  logic              ex_is_ret,
    input  logic              ex_mispredict,
    input  logic              ex_sets_cc,
    input  logic [STAT_W-1:0] ex_stat,
    input  logic [RW-1:0]     mem_dst_alu,
    input  logic [RW-1:0]     mem_dst_load,
    input  logic              mem_is_ret,
    input  logic              mem_wr_req,
    input  logic [STAT_W-1:0] mem_stat,
    input  logic [RW-1:0]     wb_dst_alu,
    input  logic [RW-1:0]     wb_dst_load,
    input  logic [STAT_W-1:0] wb_stat,
    output logic [2:0]        fwd_a_sel,
    output logic [2:0]        fwd_b_sel,
    output logic              f_stall,
    output logic              d_stall,
    output logic              d_bubble,
    output logic              e_bubble,
    output logic              m_bubble,
    output logic              w_stall,
    output logic              cc_we,
    output logic              dmem_we,
    output logic              halted
);
    localparam int NOPS = 2;

    logic [RW-1:0] srcs [NOPS];
    fwd_src_e      sels [NOPS];
    front_ctl_t    front;

    assign srcs[0] = dec_src_a;
    assign srcs[1] = dec_src_b;

    for (genvar g = 0; g < NOPS; g++) begin : g_op
        hzd_fwd_sel #(.RW(RW)) u_sel (
            .src      (srcs[g]),
            .ex_alu   (ex_dst_alu),
            .mem_load (mem_dst_load),
            .mem_alu  (mem_dst_alu),
            .wb_load  (wb_dst_load),
            .wb_alu   (wb_dst_alu),
            .sel      (sels[g])
        );
    end

    assign fwd_a_sel = sels[0];
    assign fwd_b_sel = sels[1];

    hzd_interlock #(.RW(RW)) u_lock (
        .src_a         (dec_src_a),
        .src_b         (dec_src_b),
        .dec_is_ret    (dec_is_ret),
        .ex_dst_load   (ex_dst_load),
        .ex_is_ret     (ex_is_ret),
        .ex_mispredict (ex_mispredict),
        .mem_is_ret    (mem_is_ret),
        .ctl           (front)
    );

    assign f_stall  = front.f_stall;
    assign d_stall  = front.d_stall;
    assign d_bubble = front.d_bubble;
    assign e_bubble = front.e_bubble;

    hzd_commit_guard u_guard (
        .clk        (clk),
        .rst        (rst),
        .ex_sets_cc (ex_sets_cc),
        .ex_stat    (ex_stat),
        .mem_wr_req (mem_wr_req),
        .mem_stat   (mem_stat),
        .wb_stat    (wb_stat),
        .cc_we      (cc_we),
        .dmem_we    (dmem_we),
        .m_bubble   (m_bubble),
        .w_stall    (w_stall),
        .halted     (halted)
    );
endmodule

// File: rtl/hzd_ctrl_chk.sv
module hzd_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] dec_src_a,
    input logic [3:0] ex_dst_load,
    input logic       ex_mispredict,
    input logic [1:0] mem_stat,
    input logic [1:0] wb_stat,
    input logic [2:0] fwd_a_sel,
    input logic       d_stall,
    input logic       d_bubble,
    input logic       e_bubble,
    input logic       m_bubble,
    input logic       w_stall,
    input logic       cc_we,
    input logic       dmem_we,
    input logic       halted
);
    p_none_id_r3: assert property (@(posedge clk) disable iff (rst)
        (dec_src_a == 4'hF) |-> (fwd_a_sel == 3'd0));

    p_load_use_r4: assert property (@(posedge clk) disable iff (rst)
        (dec_src_a != 4'hF && dec_src_a == ex_dst_load && !ex_mispredict)
            |-> (d_stall && e_bubble));

    p_hold_xor_kill_r5: assert property (@(posedge clk) disable iff (rst)
        !(d_stall && d_bubble));

    p_mispredict_r6: assert property (@(posedge clk) disable iff (rst)
        ex_mispredict |-> (d_bubble && e_bubble && !d_stall));

    p_no_commit_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_stat != 2'd0 || wb_stat != 2'd0) |-> (!cc_we && !dmem_we));

    p_wb_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        (wb_stat != 2'd0) |-> (w_stall && m_bubble));

    p_halt_set_r9: assert property (@(posedge clk) disable iff (rst)
        (wb_stat != 2'd0) |=> halted);

    p_halt_keep_r9: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);
endmodule

bind hzd_ctrl hzd_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .dec_src_a     (dec_src_a),
    .ex_dst_load   (ex_dst_load),
    .ex_mispredict (ex_mispredict),
    .mem_stat      (mem_stat),
    .wb_stat       (wb_stat),
    .fwd_a_sel     (fwd_a_sel),
    .d_stall       (d_stall),
    .d_bubble      (d_bubble),
    .e_bubble      (e_bubble),
    .m_bubble      (m_bubble),
    .w_stall       (w_stall),
    .cc_we         (cc_we),
    .dmem_we       (dmem_we),
    .halted        (halted)
);

// File: tb/hzd_ctrl_tb.sv
module hzd_ctrl_tb;
    logic clk = 1'b0;
    logic rst;
    logic [3:0] dec_src_a, dec_src_b, ex_dst_alu, ex_dst_load;
    logic [3:0] mem_dst_alu, mem_dst_load, wb_dst_alu, wb_dst_load;
    logic dec_is_ret, ex_is_ret, ex_mispredict, ex_sets_cc, mem_is_ret, mem_wr_req;
    logic [1:0] ex_stat, mem_stat, wb_stat;
    logic [2:0] fwd_a_sel, fwd_b_sel;
    logic f_stall, d_stall, d_bubble, e_bubble, m_bubble, w_stall, cc_we, dmem_we, halted;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    bit  exp_halted = 1'b0;

    always #4 clk = ~clk;

    hzd_ctrl u_dut (.*);

    task automatic chk(input string tag, input string nm, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, nm, act, exp, $time);
        end
    endtask

    // Reference: nearest producer wins, 0xF is "no register".
    function automatic int ref_sel(input logic [3:0] s);
        int code = 0;
        logic [3:0] order [5];
        order = '{ex_dst_alu, mem_dst_load, mem_dst_alu, wb_dst_load, wb_dst_alu};
        if (s == 4'hF) return 0;
        foreach (order[k]) if (code == 0 && order[k] == s) code = k + 1;
        return code;
    endfunction

    task automatic compare_all();
        bit lu, retp, em, ew;
        lu   = !ex_mispredict && ex_dst_load != 4'hF &&
               (ex_dst_load == dec_src_a || ex_dst_load == dec_src_b);
        retp = (dec_is_ret && !ex_mispredict) || ex_is_ret || mem_is_ret;
        em   = mem_stat != 2'd0;
        ew   = wb_stat != 2'd0;
        chk("R2/R3", "fwd_a_sel", int'(fwd_a_sel), ref_sel(dec_src_a));
        chk("R2/R3", "fwd_b_sel", int'(fwd_b_sel), ref_sel(dec_src_b));
        chk("R4/R5", "f_stall",  int'(f_stall),  int'(lu || retp));
        chk("R4/R6", "d_stall",  int'(d_stall),  int'(lu));
        chk("R5/R6", "d_bubble", int'(d_bubble), int'(ex_mispredict || (retp && !lu)));
        chk("R4/R6", "e_bubble", int'(e_bubble), int'(ex_mispredict || lu));
        chk("R8", "m_bubble", int'(m_bubble), int'(em || ew || exp_halted));
        chk("R8", "w_stall",  int'(w_stall),  int'(ew || exp_halted));
        chk("R7", "cc_we",   int'(cc_we),
            int'(ex_sets_cc && ex_stat == 2'd0 && !em && !ew && !exp_halted));
        chk("R7", "dmem_we", int'(dmem_we), int'(mem_wr_req && !em && !ew && !exp_halted));
        chk("R9", "halted",  int'(halted),  int'(exp_halted));
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
        @(posedge clk);
        if (rst) exp_halted = 1'b0;
        else if (wb_stat != 2'd0) exp_halted = 1'b1;
        #1;
    endtask

    task automatic idle();
        {dec_src_a, dec_src_b, ex_dst_alu, ex_dst_load} = {4{4'hF}};
        {mem_dst_alu, mem_dst_load, wb_dst_alu, wb_dst_load} = {4{4'hF}};
        {dec_is_ret, ex_is_ret, ex_mispredict, ex_sets_cc, mem_is_ret, mem_wr_req} = '0;
        {ex_stat, mem_stat, wb_stat} = '0;
    endtask

    function automatic logic [3:0] pick_reg();
        int r = $urandom % 8;
        if (r < 5) return 4'(r);
        if (r == 5) return 4'hF;
        return 4'($urandom);
    endfunction

    function automatic logic [1:0] pick_stat(input int odds);
        return (($urandom % odds) == 0) ? 2'(1 + $urandom % 3) : 2'd0;
    endfunction

    initial begin
        idle();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        chk("R1", "halted after reset", int'(halted), 0);

        // R2 priority: every producer writes register 2
        dec_src_a = 4'd2; dec_src_b = 4'd2;
        ex_dst_alu = 4'd2; mem_dst_load = 4'd2; mem_dst_alu = 4'd2;
        wb_dst_load = 4'd2; wb_dst_alu = 4'd2;
        step();
        ex_dst_alu = 4'hF; step();
        mem_dst_load = 4'hF; step();
        mem_dst_alu = 4'hF; step();
        wb_dst_load = 4'hF; step();
        // R3: 0xF source against 0xF producers
        idle(); ex_dst_load = 4'hF; step();
        // R4 load/use on operand B
        idle(); dec_src_b = 4'd6; ex_dst_load = 4'd6; mem_dst_load = 4'd6; step();
        // R6 with R4 in the same cycle; mispredict must win
        ex_mispredict = 1'b1; dec_src_a = 4'd6; step();
        // R5 return in decode during a load/use hold
        ex_mispredict = 1'b0; dec_is_ret = 1'b1; step();
        idle(); mem_is_ret = 1'b1; step();
        // R7/R8/R9 exception in memory, then write-back
        idle(); ex_sets_cc = 1'b1; mem_wr_req = 1'b1; step();
        mem_stat = 2'd2; step();
        mem_stat = 2'd0; wb_stat = 2'd3; step();
        wb_stat = 2'd0; step(); step();

        for (int c = 0; c < 4000; c++) begin
            rst = (c % 97) < 2;
            dec_src_a = pick_reg(); dec_src_b = pick_reg();
            ex_dst_alu = pick_reg(); ex_dst_load = pick_reg();
            mem_dst_alu = pick_reg(); mem_dst_load = pick_reg();
            wb_dst_alu = pick_reg(); wb_dst_load = pick_reg();
            dec_is_ret = ($urandom % 6) == 0;
            ex_is_ret  = ($urandom % 8) == 0;
            mem_is_ret = ($urandom % 8) == 0;
            ex_mispredict = ($urandom % 5) == 0;
            ex_sets_cc = $urandom % 2;
            mem_wr_req = $urandom % 2;
            ex_stat = pick_stat(6); mem_stat = pick_stat(8); wb_stat = pick_stat(60);
            step();
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule